// File: doc/BRIEF.md
# Multivector Coprocessor Operation Sequencer

This block steps a geometric-algebra arithmetic datapath through one complete operation. It waits in an idle phase until a start request arrives. It then walks through six phases in a fixed order: idle, clear, operand load, compute, result write and memory dump. In each phase it raises exactly one strobe to the datapath. The arithmetic pipelines, the operand memory and the host bus are outside the block; it only drives their control strobes.

The lengths of the load, compute and write/dump phases come from a 16-bit configuration word. The word is captured in the same cycle the start request is accepted. The sequencer moves between phases on its own once a phase's cycle count is used up; only the step out of idle waits on an input. A stall input lets the arithmetic pipelines drain. While it is high during the compute phase, the phase counter is frozen and the compute enable is dropped. A one-cycle completion pulse marks the return to idle.

Top module: `mvcp_seq`

## Requirements
- R1: While reset is held, and in every idle cycle, all five phase strobes and `busy_o` are low. `done_o` is low except in its single pulse cycle.
- R2: A high `start_i` sampled in an idle cycle puts the block in the clear phase on the next cycle, with `busy_o` high. `start_i` has no effect while `busy_o` is high.
- R3: The clear phase lasts exactly one cycle, with `clr_o` high, and is followed directly by the load phase.
- R4: `load_o` is high for N cycles, where N is configuration bits [3:0]. A value of 0 gives one cycle.
- R5: `run_o` is high for P non-stalled cycles, where P is configuration bits [11:4]. A value of 0 gives one cycle.
- R6: In the compute phase, a high `stall_i` keeps the block in that phase, holds the remaining count and forces `run_o` low. Outside the compute phase, `stall_i` has no effect on any output.
- R7: After the compute phase, `wr_o` is high for W cycles and then `dump_o` is high for W cycles, where W is configuration bits [15:12]. A value of 0 gives one cycle.
- R8: In the cycle after the last dump cycle, `busy_o` is low and `done_o` is high. `done_o` is high for that one cycle only.
- R9: The configuration word is captured only in the cycle a start is accepted. Changes to `cfg_i` during an operation do not alter any phase length.
- R10: At most one of `clr_o`, `load_o`, `run_o`, `wr_o`, `dump_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only when idle |
| cfg_i | input | 16 | Configuration word with the phase lengths |
| stall_i | input | 1 | Pipeline drain request, honoured in the compute phase |
| clr_o | output | 1 | Clear strobe for the datapath registers |
| load_o | output | 1 | Operand capture strobe |
| run_o | output | 1 | Compute enable |
| wr_o | output | 1 | Result write strobe |
| dump_o | output | 1 | Memory dump strobe |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `start_i`, `stall_i` and `cfg_i` are settled before each rising edge. They also assume that `stall_i` is not held high without end during the compute phase; otherwise the compute phase would never finish. They place no limit on when `start_i` may rise, since the block must ignore it while busy. The stimulus changes every input half a cycle away from the sampling edge. Stalls are applied only on some compute cycles, so each operation finishes. Extra start pulses and changed configuration words are injected in the middle of operations to show that they are ignored.

// File: rtl/mvcp_seq_pkg.sv
package mvcp_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CLEAR = 3'd1,
    PH_LOAD  = 3'd2,
    PH_PROC  = 3'd3,
    PH_WRITE = 3'd4,
    PH_DUMP  = 3'd5
  } phase_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/mvcp_seq_cfg.sv
module mvcp_seq_cfg #(
  parameter int unsigned CFG_W = 16,
  parameter int unsigned LD_W  = 4,
  parameter int unsigned PR_W  = 8,
  parameter int unsigned XF_W  = 4,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [CNT_W-1:0] ld_last_o,
  output logic [CNT_W-1:0] pr_last_o,
  output logic [CNT_W-1:0] xf_last_o
);

  localparam int unsigned PR_LO = LD_W;
  localparam int unsigned XF_LO = LD_W + PR_W;

  logic [CFG_W-1:0] cfg_q;
  logic [LD_W-1:0]  ld_f;
  logic [PR_W-1:0]  pr_f;
  logic [XF_W-1:0]  xf_f;

  // Capture only when a start is accepted; later changes are ignored.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cap_i) begin
      cfg_q <= cfg_i;
    end
  end

  assign ld_f = cfg_q[LD_W-1:0];
  assign pr_f = cfg_q[PR_LO +: PR_W];
  assign xf_f = cfg_q[XF_LO +: XF_W];

  // Counter preload is length minus one; a zero field counts as one cycle.
  always_comb begin
    ld_last_o = (ld_f == '0) ? '0 : CNT_W'(ld_f) - CNT_W'(1);
    pr_last_o = (pr_f == '0) ? '0 : CNT_W'(pr_f) - CNT_W'(1);
    xf_last_o = (xf_f == '0) ? '0 : CNT_W'(xf_f) - CNT_W'(1);
  end

endmodule

// File: rtl/mvcp_seq_cnt.sv
module mvcp_seq_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i | dec_i;
    cnt_d  = load_i ? load_val_i : (cnt_q - W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/mvcp_seq_fsm.sv
module mvcp_seq_fsm
  import mvcp_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   stall_i,
  input  logic   cnt_zero_i,
  output phase_e state_o,
  output phase_e nxt_o,
  output logic   adv_o,
  output logic   hold_o,
  output logic   done_o
);

  phase_e st_q;
  phase_e st_d;
  logic   done_d;

  always_comb begin
    hold_o = (st_q == PH_PROC) && stall_i;

    unique case (st_q)
      PH_IDLE:  nxt_o = PH_CLEAR;
      PH_CLEAR: nxt_o = PH_LOAD;
      PH_LOAD:  nxt_o = PH_PROC;
      PH_PROC:  nxt_o = PH_WRITE;
      PH_WRITE: nxt_o = PH_DUMP;
      default:  nxt_o = PH_IDLE;
    endcase

    if (st_q == PH_IDLE) begin
      adv_o = start_i;
    end else begin
      adv_o = cnt_zero_i && !hold_o;
    end

    st_d   = adv_o ? nxt_o : st_q;
    done_d = (st_q == PH_DUMP) && adv_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      done_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= done_d;
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/mvcp_seq.sv
module mvcp_seq
  import mvcp_seq_pkg::*;
#(
  parameter int unsigned CFG_W = 16,
  parameter int unsigned LD_W  = 4,
  parameter int unsigned PR_W  = 8,
  parameter int unsigned XF_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             stall_i,
  output logic             clr_o,
  output logic             load_o,
  output logic             run_o,
  output logic             wr_o,
  output logic             dump_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam int unsigned CNT_W = max3(LD_W, PR_W, XF_W);

  phase_e           state;
  phase_e           nxt;
  logic             adv;
  logic             hold;
  logic             cnt_zero;
  logic             cnt_dec;
  logic [CNT_W-1:0] cnt_val;
  logic [CNT_W-1:0] ld_last;
  logic [CNT_W-1:0] pr_last;
  logic [CNT_W-1:0] xf_last;
  logic             cap;

  assign cap = (state == PH_IDLE) && start_i;

  mvcp_seq_cfg #(
    .CFG_W (CFG_W),
    .LD_W  (LD_W),
    .PR_W  (PR_W),
    .XF_W  (XF_W),
    .CNT_W (CNT_W)
  ) cfg_i0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_i     (cap),
    .cfg_i     (cfg_i),
    .ld_last_o (ld_last),
    .pr_last_o (pr_last),
    .xf_last_o (xf_last)
  );

  mvcp_seq_fsm fsm_i0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .stall_i    (stall_i),
    .cnt_zero_i (cnt_zero),
    .state_o    (state),
    .nxt_o      (nxt),
    .adv_o      (adv),
    .hold_o     (hold),
    .done_o     (done_o)
  );

  // Preload for the phase being entered; clear is a single cycle.
  always_comb begin
    unique case (nxt)
      PH_LOAD:  cnt_val = ld_last;
      PH_PROC:  cnt_val = pr_last;
      PH_WRITE: cnt_val = xf_last;
      PH_DUMP:  cnt_val = xf_last;
      default:  cnt_val = '0;
    endcase
    cnt_dec = (state != PH_IDLE) && !adv && !hold;
  end

  mvcp_seq_cnt #(
    .W (CNT_W)
  ) cnt_i0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (adv),
    .load_val_i (cnt_val),
    .dec_i      (cnt_dec),
    .zero_o     (cnt_zero)
  );

  always_comb begin
    clr_o  = (state == PH_CLEAR);
    load_o = (state == PH_LOAD);
    run_o  = (state == PH_PROC) && !stall_i;
    wr_o   = (state == PH_WRITE);
    dump_o = (state == PH_DUMP);
    busy_o = (state != PH_IDLE);
  end

endmodule

// File: rtl/mvcp_seq_chk.sv
module mvcp_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic stall_i,
  input logic clr_o,
  input logic load_o,
  input logic run_o,
  input logic wr_o,
  input logic dump_o,
  input logic busy_o,
  input logic done_o
);

  logic in_proc;
  assign in_proc = busy_o && !clr_o && !load_o && !wr_o && !dump_o;

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_o, load_o, run_o, wr_o, dump_o}));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(clr_o || load_o || run_o || wr_o || dump_o));

  p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (clr_o && busy_o));

  p_clear_to_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |=> load_o);

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_proc && stall_i) |=> (busy_o && !wr_o && !dump_o && !clr_o && !load_o));

  p_stall_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> !run_o);

  p_write_then_dump_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |=> (wr_o || dump_o));

  p_done_after_dump_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(dump_o)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

bind mvcp_seq mvcp_seq_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .stall_i (stall_i),
  .clr_o   (clr_o),
  .load_o  (load_o),
  .run_o   (run_o),
  .wr_o    (wr_o),
  .dump_o  (dump_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/mvcp_seq_tb_top.sv
module mvcp_seq_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [15:0] cfg_i;
  logic        stall_i;
  logic        clr_o, load_o, run_o, wr_o, dump_o, busy_o, done_o;

  int checks;
  int failures;
  bit finished;

  typedef struct {
    logic [6:0] vec;
    string      tag;
  } exp_t;

  exp_t sbq[$];

  // Vector order: busy, clr, load, run, wr, dump, done
  localparam logic [6:0] V_IDLE  = 7'b0000000;
  localparam logic [6:0] V_CLR   = 7'b1100000;
  localparam logic [6:0] V_LOAD  = 7'b1010000;
  localparam logic [6:0] V_RUN   = 7'b1001000;
  localparam logic [6:0] V_STALL = 7'b1000000;
  localparam logic [6:0] V_WR    = 7'b1000100;
  localparam logic [6:0] V_DUMP  = 7'b1000010;
  localparam logic [6:0] V_DONE  = 7'b0000001;

  mvcp_seq dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .cfg_i   (cfg_i),
    .stall_i (stall_i),
    .clr_o   (clr_o),
    .load_o  (load_o),
    .run_o   (run_o),
    .wr_o    (wr_o),
    .dump_o  (dump_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [6:0] act_vec();
    return {busy_o, clr_o, load_o, run_o, wr_o, dump_o, done_o};
  endfunction

  task automatic check(input logic [6:0] act, input logic [6:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: samples one time unit after the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        checks++;
        if ($countones({clr_o, load_o, run_o, wr_o, dump_o}) > 1) begin
          failures++;
          $display("FAIL R10: actual=%b expected=at most one strobe",
                   {clr_o, load_o, run_o, wr_o, dump_o});
        end
        if (sbq.size() > 0) begin
          exp_t e;
          e = sbq.pop_front();
          check(act_vec(), e.vec, e.tag);
        end
      end
    end
  end

  task automatic step(input logic [6:0] v, input bit stl, input bit noise, input string tag);
    @(negedge clk);
    start_i = noise;
    stall_i = stl;
    if (noise) cfg_i = cfg_i ^ 16'h5a5a;
    sbq.push_back('{vec: v, tag: tag});
  endtask

  // stall_mode: 0 none, 1 stall every third compute slot, 2 stall outside compute only
  task automatic run_op(input logic [15:0] cfg, input int stall_mode, input bit noise,
                        input string note);
    int nl, np, nw, k, rem;
    bit s_out;
    nl = (cfg[3:0] == 0) ? 1 : int'(cfg[3:0]);
    np = (cfg[11:4] == 0) ? 1 : int'(cfg[11:4]);
    nw = (cfg[15:12] == 0) ? 1 : int'(cfg[15:12]);
    s_out = (stall_mode == 2);
    @(negedge clk);
    start_i = 1'b1;
    cfg_i   = cfg;
    stall_i = s_out;
    sbq.push_back('{vec: V_IDLE, tag: {"R1 ", note}});
    step(V_CLR, s_out, noise, {"R2 R3 ", note});
    for (int i = 0; i < nl; i++) step(V_LOAD, s_out, noise, {"R4 R9 ", note});
    k = 0;
    rem = np;
    while (rem > 0) begin
      if (stall_mode == 1 && (k % 3) == 1) begin
        step(V_STALL, 1'b1, noise, {"R6 ", note});
      end else begin
        step(V_RUN, 1'b0, noise, {"R5 R9 ", note});
        rem--;
      end
      k++;
    end
    for (int i = 0; i < nw; i++) step(V_WR, s_out, noise, {"R7 R9 ", note});
    for (int i = 0; i < nw; i++) step(V_DUMP, s_out, noise, {"R7 R9 ", note});
    step(V_DONE, s_out, 1'b0, {"R8 ", note});
    step(V_IDLE, 1'b0, 1'b0, {"R8 R1 ", note});
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    finished = 0;
    rst_n    = 1'b0;
    start_i  = 1'b0;
    cfg_i    = 16'h0;
    stall_i  = 1'b0;
    repeat (2) @(posedge clk);
    start_i = 1'b1;
    @(negedge clk);
    #1;
    check(act_vec(), V_IDLE, "R1 during reset");
    @(negedge clk);
    rst_n   = 1'b1;
    start_i = 1'b0;
    #1;
    check(act_vec(), V_IDLE, "R1 after reset");

    run_op(16'h1032, 0, 1'b0, "basic");
    run_op(16'h0000, 0, 1'b0, "zero fields");
    run_op(16'hF05F, 1, 1'b1, "stall and noise");
    run_op(16'h3043, 2, 1'b0, "stall outside compute");
    run_op(16'h2FF1, 1, 1'b1, "long compute");
    run_op(16'h0011, 1, 1'b0, "single compute");

    while (sbq.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule